// File: doc/BRIEF.md
# Multi-Queue Pipe Switching Executor

This block is a single execution pipe that owns a small set of queue slots. Each slot has its own command FIFO, filled by a producer through a valid/ready push port, and a mapped flag driven from outside. At any moment the pipe is resident on at most one slot, which is its active slot. The pipe pops command words from that slot and presents them on a valid/ready output stream.

Commands are grouped into packets. A packet is a header word followed by as many payload words as the header's length field gives. The pipe leaves the current slot for one of three reasons:

- **Stream-command mode:** a switch marker appears in the stream.
- **Packet mode:** a packet has been fully accepted.
- **Either mode:** an external agent raised a switch request; this takes effect only at a packet boundary.

The next slot is picked round-robin among the slots that are mapped and hold data.

The controller has three named states:

- **SELECT:** no slot is active. The next slot is chosen. The transition SELECT→HEADER is taken when an eligible slot exists.
- **HEADER:** the pipe is at a packet boundary on the active slot.
  - HEADER→PAYLOAD when a header with a nonzero length is accepted.
  - HEADER→HEADER when a zero-length header is accepted in stream-command mode.
  - HEADER→SELECT when any of these holds: a zero-length header is accepted in packet mode, a marker is dropped, a request is pending, the slot was unmapped, or the slot is empty.
- **PAYLOAD:** payload words are counted out. On the last accepted word, PAYLOAD→SELECT in packet mode and PAYLOAD→HEADER in stream-command mode.

Top module: `pq_pipe_exec`

## Requirements
- R1: At most one slot is active at any time. A FIFO is popped only while its slot is active, and at most one FIFO is popped per cycle. While out_valid is high, slot_active has exactly the bit of cur_slot set.
- R2: A slot whose slot_mapped bit is low is never selected. None of its words reach the output, and once no mapped slot has data, slot_active is all zero.
- R3: In stream-command mode (pkt_mode=0), a word at a header position whose bits [15:12] equal 4'hF is a switch marker. It is popped and not emitted, and selection then moves to the next eligible slot.
- R4: In packet mode (pkt_mode=1), the pipe reselects after the last word of every packet is accepted. A word with bits [15:12]=4'hF is forwarded as an ordinary packet.
- R5: A pulse on ext_switch is held until the next packet boundary and then forces a reselection. cur_slot never changes in the middle of a packet.
- R6: Selection searches round-robin, starting at the slot after cur_slot and wrapping. The current slot is chosen again only if no other slot is mapped and non-empty.
- R7: When no mapped slot holds data, out_valid stays low and cur_slot holds its value.
- R8: A header's bits [3:0] give N. The header is emitted first, followed by exactly N payload words from the same slot, in FIFO order.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.
- R10: After reset, out_valid is 0, slot_active is 0, cur_slot equals NQ-1 (so the first search starts at slot 0), and every in_ready bit is 1.
- R11: A FIFO holding DEPTH words drives its in_ready bit low. A word pushed while in_ready is low is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_mode | input | 1 | 1 selects packet mode, 0 selects stream-command mode |
| slot_mapped | input | NQ | Per-slot mapped flag |
| in_valid | input | NQ | Per-slot push strobe |
| in_data | input | NQ*DW | Per-slot push words, with slot k in bits [k*DW +: DW] |
| in_ready | output | NQ | Per-slot FIFO not full |
| ext_switch | input | 1 | External switch request pulse |
| out_valid | output | 1 | Output word valid |
| out_data | output | DW | Output command word |
| out_ready | input | 1 | Downstream accepts the word |
| cur_slot | output | QW | Index of the current slot |
| slot_active | output | NQ | Active flags, with at most one bit set |

## Verification
A wrong state value or a stale remaining-word count shows at the ports within one packet. A payload word would then be emitted as a header, a word would be dropped, or the slot would change in the middle of a packet. The bench catches this by comparing the complete word-and-slot sequence against an order it computes itself. A lost or stuck switch request reorders the stream at the very next packet boundary. A faulty arbiter picks the wrong slot on the first reselection after reset.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        ST_SELECT  = 2'd0,
        ST_HEADER  = 2'd1,
        ST_PAYLOAD = 2'd2
    } pq_state_e;

    localparam int          PQ_OPW       = 4;
    localparam logic [3:0]  PQ_OP_SWITCH = 4'hF;

endpackage

// File: rtl/pq_fifo.sv
module pq_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          nonempty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full     = (count == CW'(DEPTH));
    assign nonempty = (count != '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && nonempty;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !do_pop) |=> full);

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);

endmodule

// File: rtl/pq_rr_pick.sv
module pq_rr_pick #(
    parameter int NQ = 2,
    parameter int QW = 1
) (
    input  logic [NQ-1:0] eligible,
    input  logic [QW-1:0] cur,
    output logic          pick_ok,
    output logic [QW-1:0] pick_idx
);
    always_comb begin
        pick_ok  = 1'b0;
        pick_idx = cur;
        for (int k = 1; k <= NQ; k++) begin
            int t;
            t = int'(cur) + k;
            if (t >= NQ) begin
                t = t - NQ;
            end
            if (!pick_ok && eligible[t]) begin
                pick_ok  = 1'b1;
                pick_idx = QW'(t);
            end
        end
    end

endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
    import pq_pkg::*;
#(
    parameter int NQ   = 2,
    parameter int QW   = 1,
    parameter int DW   = 16,
    parameter int LENW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_mode,
    input  logic [NQ-1:0]    mapped,
    input  logic [NQ-1:0]    nonempty,
    input  logic [NQ*DW-1:0] heads,
    input  logic             ext_switch,
    input  logic             pick_ok,
    input  logic [QW-1:0]    pick_idx,
    input  logic             out_ready,
    output logic [NQ-1:0]    pop,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic [QW-1:0]    cur_slot,
    output logic [NQ-1:0]    slot_active
);
    pq_state_e       st, st_nx;
    logic [QW-1:0]   cur_q;
    logic [LENW-1:0] left, left_nx;
    logic            offered;
    logic            pend;
    logic [DW-1:0]   head;
    logic            sel_map, sel_ne, is_sw, fire, drop_sw, leave_hdr;
    logic [LENW-1:0] hdr_len;

    assign head      = heads[cur_q*DW +: DW];
    assign sel_map   = mapped[cur_q];
    assign sel_ne    = nonempty[cur_q];
    assign is_sw     = !pkt_mode && (head[DW-1 -: PQ_OPW] == PQ_OP_SWITCH);
    assign hdr_len   = head[LENW-1:0];
    assign leave_hdr = !offered && (!sel_map || !sel_ne || pend || is_sw);
    assign fire      = out_valid && out_ready;

    // Output process
    always_comb begin
        out_valid   = 1'b0;
        drop_sw     = 1'b0;
        slot_active = '0;
        pop         = '0;
        unique case (st)
            ST_SELECT: begin
            end
            ST_HEADER: begin
                out_valid = offered || (sel_map && sel_ne && !pend && !is_sw);
                drop_sw   = !offered && sel_map && sel_ne && !pend && is_sw;
                slot_active[cur_q] = 1'b1;
            end
            ST_PAYLOAD: begin
                out_valid = sel_ne;
                slot_active[cur_q] = 1'b1;
            end
            default: begin
            end
        endcase
        if ((out_valid && out_ready) || drop_sw) begin
            pop[cur_q] = 1'b1;
        end
    end

    assign out_data = head;
    assign cur_slot = cur_q;

    // Next-state process
    always_comb begin
        st_nx   = st;
        left_nx = left;
        unique case (st)
            ST_SELECT: begin
                if (pick_ok) begin
                    st_nx = ST_HEADER;
                end
            end
            ST_HEADER: begin
                if (fire) begin
                    if (hdr_len == '0) begin
                        st_nx = pkt_mode ? ST_SELECT : ST_HEADER;
                    end else begin
                        st_nx   = ST_PAYLOAD;
                        left_nx = hdr_len;
                    end
                end else if (leave_hdr) begin
                    st_nx = ST_SELECT;
                end
            end
            ST_PAYLOAD: begin
                if (fire) begin
                    left_nx = left - 1'b1;
                    if (left == LENW'(1)) begin
                        st_nx = pkt_mode ? ST_SELECT : ST_HEADER;
                    end
                end
            end
            default: st_nx = ST_SELECT;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_SELECT;
            left    <= '0;
            cur_q   <= QW'(NQ - 1);
            offered <= 1'b0;
            pend    <= 1'b0;
        end else begin
            st      <= st_nx;
            left    <= left_nx;
            offered <= (st == ST_HEADER) && out_valid && !out_ready;
            pend    <= (st == ST_SELECT) ? 1'b0 : (pend || ext_switch);
            if (st == ST_SELECT && pick_ok) begin
                cur_q <= pick_idx;
            end
        end
    end

    p_active_mapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SELECT && pick_ok) |-> (mapped[pick_idx] && nonempty[pick_idx]));

    p_switch_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> ($past(st) == ST_SELECT));

    p_payload_keeps_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAYLOAD) |=> $stable(cur_q));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SELECT && !pick_ok) |=> ($stable(cur_q) && !out_valid));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/pq_pipe_exec.sv
module pq_pipe_exec #(
    parameter int NQ    = 2,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int LENW  = 4,
    localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_mode,
    input  logic [NQ-1:0]    slot_mapped,
    input  logic [NQ-1:0]    in_valid,
    input  logic [NQ*DW-1:0] in_data,
    output logic [NQ-1:0]    in_ready,
    input  logic             ext_switch,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    input  logic             out_ready,
    output logic [QW-1:0]    cur_slot,
    output logic [NQ-1:0]    slot_active
);
    logic [NQ-1:0]    fifo_pop;
    logic [NQ-1:0]    fifo_full;
    logic [NQ-1:0]    fifo_ne;
    logic [NQ*DW-1:0] fifo_heads;
    logic             pick_ok;
    logic [QW-1:0]    pick_idx;

    for (genvar g = 0; g < NQ; g++) begin : g_slot
        pq_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (in_valid[g]),
            .wdata    (in_data[g*DW +: DW]),
            .pop      (fifo_pop[g]),
            .head     (fifo_heads[g*DW +: DW]),
            .full     (fifo_full[g]),
            .nonempty (fifo_ne[g])
        );
        assign in_ready[g] = !fifo_full[g];
    end

    pq_rr_pick #(.NQ(NQ), .QW(QW)) pick_i (
        .eligible (slot_mapped & fifo_ne),
        .cur      (cur_slot),
        .pick_ok  (pick_ok),
        .pick_idx (pick_idx)
    );

    pq_ctrl #(.NQ(NQ), .QW(QW), .DW(DW), .LENW(LENW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pkt_mode    (pkt_mode),
        .mapped      (slot_mapped),
        .nonempty    (fifo_ne),
        .heads       (fifo_heads),
        .ext_switch  (ext_switch),
        .pick_ok     (pick_ok),
        .pick_idx    (pick_idx),
        .out_ready   (out_ready),
        .pop         (fifo_pop),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .cur_slot    (cur_slot),
        .slot_active (slot_active)
    );

    p_single_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_pop));

    p_pop_in_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_pop) |-> (fifo_pop == slot_active));

    p_one_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_active) <= 1);

endmodule

// File: tb/pq_pipe_exec_tb_top.sv
module pq_pipe_exec_tb_top;
    localparam int NQ = 2;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_mode = 1'b0;
    logic [NQ-1:0] slot_mapped = '0;
    logic [NQ-1:0] in_valid = '0;
    logic [NQ*DW-1:0] in_data = '0;
    logic [NQ-1:0] in_ready;
    logic          ext_switch = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ready;
    logic [0:0]    cur_slot;
    logic [NQ-1:0] slot_active;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rdy_pat = 0;
    bit done = 0;

    logic [DW-1:0] got_w [64];
    int            got_q [64];
    int            ngot = 0;
    logic [DW-1:0] exp_w [64];
    int            exp_q [64];
    int            nexp = 0;
    int            act_err = 0;
    int            stall_err = 0;
    bit            prev_stall = 0;
    logic [DW-1:0] prev_data = '0;

    always #10 clk = ~clk;

    pq_pipe_exec dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_mode(pkt_mode), .slot_mapped(slot_mapped),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .ext_switch(ext_switch), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .cur_slot(cur_slot), .slot_active(slot_active)
    );

    always @(posedge clk) begin
        cyc++;
        #1;
        out_ready = (rdy_pat == 0) || ((cyc % 3) != 0);
    end

    // Monitor at the falling edge: record handshakes, check R1 and R9.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && !(out_valid && out_data == prev_data)) stall_err++;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && slot_active != (NQ'(1) << cur_slot)) act_err++;
            if ($countones(slot_active) > 1) act_err++;
            if (out_valid && out_ready && ngot < 64) begin
                got_w[ngot] = out_data;
                got_q[ngot] = int'(cur_slot);
                ngot++;
            end
        end else begin
            prev_stall = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] hdr(input int q, input int p, input int len);
        return {4'h1, 4'(q), 4'(p), 4'(len)};
    endfunction

    function automatic logic [DW-1:0] pay(input int q, input int p, input int i);
        return {4'hA, 4'(q), 4'(p), 4'(i)};
    endfunction

    task automatic push(input int q, input logic [DW-1:0] w);
        in_data[q*DW +: DW] = w;
        in_valid[q] = 1'b1;
        @(posedge clk); #1;
        in_valid[q] = 1'b0;
    endtask

    task automatic push_pkt(input int q, input int p, input int len);
        push(q, hdr(q, p, len));
        for (int i = 0; i < len; i++) push(q, pay(q, p, i));
    endtask

    task automatic add_w(input logic [DW-1:0] w, input int q);
        exp_w[nexp] = w;
        exp_q[nexp] = q;
        nexp++;
    endtask

    task automatic add_pkt(input int q, input int p, input int len);
        add_w(hdr(q, p, len), q);
        for (int i = 0; i < len; i++) add_w(pay(q, p, i), q);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        slot_mapped = '0;
        in_valid = '0;
        ext_switch = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        ngot = 0;
        nexp = 0;
        act_err = 0;
        stall_err = 0;
    endtask

    // Wait for the expected words, then compare the sequence and the idle state (R7).
    task automatic finish_case(input string req);
        logic [0:0] held;
        for (int t = 0; t < 400 && ngot < nexp; t++) @(posedge clk);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(ngot == nexp, {req, " word count"}, ngot, nexp);
        for (int i = 0; i < nexp && i < ngot; i++) begin
            chk(got_w[i] == exp_w[i], {req, " R8 word"}, int'(got_w[i]), int'(exp_w[i]));
            chk(got_q[i] == exp_q[i], {req, " R6 slot"}, got_q[i], exp_q[i]);
        end
        held = cur_slot;
        chk(out_valid == 1'b0, "R7 valid low when drained", int'(out_valid), 0);
        repeat (4) @(negedge clk);
        chk(cur_slot == held, "R7 selection held", int'(cur_slot), int'(held));
        chk(out_valid == 1'b0, "R7 valid stays low", int'(out_valid), 0);
        chk(act_err == 0, "R1 single active slot", act_err, 0);
        chk(stall_err == 0, "R9 stall hold", stall_err, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(out_valid == 1'b0, "R10 valid", int'(out_valid), 0);
        chk(slot_active == '0, "R10 active", int'(slot_active), 0);
        chk(cur_slot == 1'(NQ - 1), "R10 cur_slot", int'(cur_slot), NQ - 1);
        chk(in_ready == '1, "R10 in_ready", int'(in_ready), 3);

        // R4 packet-mode sweep over lengths, with and without back-pressure
        for (int la = 0; la < 3; la++) begin
            for (int lb = 0; lb < 3; lb++) begin
                do_reset();
                rdy_pat = (la + lb) % 2;
                pkt_mode = 1'b1;
                push_pkt(0, 0, la); push_pkt(0, 1, la);
                push_pkt(1, 0, lb); push_pkt(1, 1, lb);
                add_pkt(0, 0, la); add_pkt(1, 0, lb);
                add_pkt(0, 1, la); add_pkt(1, 1, lb);
                slot_mapped = 2'b11;
                finish_case("R4 packet rotation");
            end
        end
        rdy_pat = 0;

        // R3 stream mode: the marker is dropped and causes a switch
        do_reset();
        pkt_mode = 1'b0;
        push_pkt(0, 0, 1); push(0, 16'hF000); push_pkt(0, 1, 0);
        push_pkt(1, 0, 2);
        add_pkt(0, 0, 1); add_pkt(1, 0, 2); add_pkt(0, 1, 0);
        slot_mapped = 2'b11;
        finish_case("R3 stream marker");

        // R4 packet mode forwards a marker-coded word as a packet; R6 keeps the only eligible slot
        do_reset();
        pkt_mode = 1'b1;
        push(0, 16'hF000); push_pkt(0, 1, 2);
        add_w(16'hF000, 0); add_pkt(0, 1, 2);
        slot_mapped = 2'b11;
        finish_case("R4 marker forwarded");

        // R5 external request during a payload takes effect at the boundary
        do_reset();
        pkt_mode = 1'b0;
        push_pkt(0, 0, 3); push_pkt(0, 1, 1);
        push_pkt(1, 0, 0);
        add_pkt(0, 0, 3); add_pkt(1, 0, 0); add_pkt(0, 1, 1);
        slot_mapped = 2'b11;
        wait (ngot == 2);
        @(posedge clk); #1;
        ext_switch = 1'b1;
        @(posedge clk); #1;
        ext_switch = 1'b0;
        finish_case("R5 external switch");

        // R2 unmapped slot is never selected
        do_reset();
        pkt_mode = 1'b1;
        push_pkt(0, 0, 1);
        push_pkt(1, 0, 1);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R2 nothing mapped", int'(out_valid), 0);
        add_pkt(1, 0, 1);
        slot_mapped = 2'b10;
        finish_case("R2 mapped only");
        chk(slot_active == '0, "R2 unmapped slot idle", int'(slot_active), 0);

        // R11 full FIFO refuses further words
        do_reset();
        pkt_mode = 1'b0;
        push_pkt(0, 0, 3); push_pkt(0, 1, 3);
        @(negedge clk);
        chk(in_ready[0] == 1'b0, "R11 full", int'(in_ready[0]), 0);
        push(0, hdr(0, 7, 0));
        add_pkt(0, 0, 3); add_pkt(0, 1, 3);
        slot_mapped = 2'b01;
        finish_case("R11 overflow dropped");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule